// File: doc/BRIEF.md
# Microsecond Timebase with Rational Prescaler

This block turns a reference clock into a steady one-microsecond tick and counts those ticks in a free-running up-counter. The reference may run at 12, 13, 19.2 or 26 MHz. Instead of a plain integer divider, the prescaler takes a numerator and a denominator. It can therefore produce an exact 1 MHz average from a reference that is not a whole multiple of 1 MHz, such as 19.2 MHz, which gives five ticks in every 96 reference cycles.

Software reaches the block through a small register port with three registers. The first holds the prescaler setting and returns exactly what was written, so it can be saved and restored. The second is the tick counter, which is read-only. The third holds a freeze bit that stops the prescaler and the counter together. The block also drives a one-cycle pulse, `us_tick`, that other timers can use as their microsecond enable.

Top module: `utb_timebase`

## Requirements
- R1: After reset the rate setting reads 0x0000000B, the counter reads 0, the freeze bit reads 0 and `us_tick` is low.
- R2: Register offsets are 0x10 for the counter (zero-extended to 32 bits), 0x14 for the rate setting and 0x4C for freeze (bit 0). Read data appears on `bus_rdata` in the cycle after the read request. Any other offset reads 0. Writes to the counter offset or to an unmapped offset change nothing.
- R3: The rate register stores write-data bits [15:0] and returns them on read with bits [31:16] as zero. Its value holds until the next write to it.
- R4: Bits [7:0] of the rate setting hold the denominator minus one, and bits [15:8] hold the numerator minus one. When the numerator is smaller than the denominator, the block emits exactly numerator ticks in every denominator enabled cycles. The spacing between ticks is always the floor or the ceiling of denominator/numerator (for example, 0x0206 gives gaps of 2 or 3 cycles and 3 ticks per 7 cycles).
- R5: The four reference settings give 1 MHz. 0x000B gives a tick every 12 cycles, 0x000C every 13 cycles and 0x0019 every 26 cycles. 0x045F gives gaps of 19 or 20 cycles, with 5 ticks per 96 cycles.
- R6: When the numerator is greater than or equal to the denominator, a tick is emitted on every enabled cycle.
- R7: `us_tick` is a one-cycle pulse. The counter advances by exactly one for each pulse, and the new value is in place during the cycle the pulse is high.
- R8: The counter wraps from its maximum value to zero and keeps counting.
- R9: Writing 1 to freeze bit 0 stops the block from the following cycle: no ticks, and the counter and prescaler phase hold. Register reads keep working during freeze. After freeze is cleared, tick spacing counted in enabled cycles continues as if there had been no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| us_tick | output | 1 | One-cycle microsecond pulse |

## Verification
A corrupted prescaler accumulator shows up directly at `us_tick`. Tick gaps fall outside the floor/ceiling pair, or the tick count in a window of one denominator period is wrong, and either shows within one denominator period. A counter that drifts from the pulse stream shows at the next counter read, when the value no longer matches the number of pulses seen on `us_tick`. A freeze that leaks shows as a pulse during the hold, or as a shifted tick phase on the first gap after release.

// File: rtl/utb_pkg.sv
package utb_pkg;
  localparam int FRAC_W = 8;
  localparam int CFG_W  = 2 * FRAC_W;

  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_RATE   = 8'h14;
  localparam logic [7:0] OFS_FREEZE = 8'h4c;

  localparam logic [CFG_W-1:0] RATE_RESET = 16'h000b;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } rate_cfg_t;
endpackage

// File: rtl/utb_regs.sv
module utb_regs
  import utb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output rate_cfg_t         rate,
  output logic              freeze,
  output logic [DATA_W-1:0] rdata
);
  logic hit_cnt, hit_rate, hit_frz;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign hit_cnt  = (addr == ADDR_W'(OFS_COUNT));
  assign hit_rate = (addr == ADDR_W'(OFS_RATE));
  assign hit_frz  = (addr == ADDR_W'(OFS_FREEZE));
  assign unused_wdata = ^wdata[DATA_W-1:CFG_W];

  always_comb begin
    rd_mux = '0;
    if (hit_cnt)  rd_mux = DATA_W'(count);
    if (hit_rate) rd_mux = DATA_W'(rate);
    if (hit_frz)  rd_mux = DATA_W'(freeze);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate   <= rate_cfg_t'(RATE_RESET);
      freeze <= 1'b0;
      rdata  <= '0;
    end else begin
      if (sel && wr && hit_rate) rate <= rate_cfg_t'(wdata[CFG_W-1:0]);
      if (sel && wr && hit_frz)  freeze <= wdata[0];
      if (sel && !wr)            rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/utb_rate_acc.sv
module utb_rate_acc
  import utb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cfg_t rate,
  input  logic      hold,
  output logic      step,
  output logic      tick
);
  localparam int W1 = FRAC_W + 1;
  localparam int W2 = FRAC_W + 2;

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [W1-1:0] num, den;
  logic [W2-1:0] sum;
  logic fire;

  always_comb begin
    num = W1'(rate.num_m1) + W1'(1);
    den = W1'(rate.den_m1) + W1'(1);
    sum = W2'(acc_q) + W2'(num);
    if (num >= den) begin
      fire  = 1'b1;
      acc_d = '0;
    end else if (sum >= W2'(den)) begin
      fire  = 1'b1;
      acc_d = FRAC_W'(sum - W2'(den));
    end else begin
      fire  = 1'b0;
      acc_d = FRAC_W'(sum);
    end
  end

  assign step = fire && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (hold) begin
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= fire;
    end
  end
endmodule

// File: rtl/utb_us_counter.sv
module utb_us_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/utb_timebase.sv
module utb_timebase
  import utb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              us_tick
);
  rate_cfg_t        rate_w;
  logic             freeze_w;
  logic             step_w;
  logic [CNT_W-1:0] count_w;

  utb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk_ref), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .count(count_w),
    .rate(rate_w), .freeze(freeze_w), .rdata(bus_rdata)
  );

  utb_rate_acc u_acc (
    .clk(clk_ref), .rst_n(rst_n), .rate(rate_w), .hold(freeze_w),
    .step(step_w), .tick(us_tick)
  );

  utb_us_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .step(step_w), .count(count_w)
  );
endmodule

// File: rtl/utb_timebase_chk.sv
module utb_timebase_chk
  import utb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic              freeze,
  input rate_cfg_t         rate
);
  logic rate_wr;
  logic fast;
  assign rate_wr = sel && wr && (addr == ADDR_W'(OFS_RATE));
  assign fast = ({1'b0, rate.num_m1} >= {1'b0, rate.den_m1});

  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !tick); // R9
  AST_FROZEN_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(count)); // R9
  AST_COUNT_STEPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (count == CNT_W'($past(count) + 1'b1))); // R7
  AST_COUNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> $stable(count)); // R7
  AST_RATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_wr |=> $stable(rate)); // R3
  AST_FAST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && !freeze) |=> tick); // R6
endmodule

bind utb_timebase utb_timebase_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
  .tick(us_tick), .count(count_w), .freeze(freeze_w), .rate(rate_w)
);

// File: tb/tb_utb_timebase.sv
module tb_utb_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int SETTLE     = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        us_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  utb_timebase #(.ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W)) dut (
    .clk_ref(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .us_tick(us_tick)
  );

  typedef struct {
    logic [31:0] exp;
    bit          is_cnt;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // stimulus-controlled monitor settings
  bit    gap_on = 0;
  int    gap_lo = 0, gap_hi = 0;
  string gap_tag = "";
  bit    win_req = 0;
  int    win_len = 0, win_exp = 0;
  string win_tag = "";

  // monitor state
  bit rst_prev = 0;
  bit frz_m = 0;
  bit p_rd = 0, p_frz_wr = 0, p_frz_val = 0, p_rate_wr = 0;
  int since_tick = 0, settle = 0, win_left = 0, win_ticks = 0;
  bit have_prev = 0;
  int ticks_seen = 0;
  bit reset_checked = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] e, bit is_cnt, string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.exp = e; it.is_cnt = is_cnt; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rate_case(logic [15:0] c, int lo, int hi, int wlen, int wexp, string tag);
    bus_write(8'h14, {16'h0, c});
    gap_lo = lo; gap_hi = hi; gap_tag = tag;
    win_len = wlen; win_exp = wexp; win_tag = tag; win_req = 1;
    gap_on = 1;
    repeat (SETTLE + 4*wlen + 60) @(posedge clk);
    #1 gap_on = 0;
    bus_read(8'h14, {16'h0, c}, 0, "R3 rate readback");
  endtask

  // monitor: samples at the falling edge, accounts for the preceding rising edge
  always @(negedge clk) begin
    if (!rst_prev) begin
      if (!rst_n && !reset_checked) begin
        chk(us_tick == 1'b0, "R1 tick low in reset", 32'(us_tick), 32'h0);
        reset_checked = 1;
      end
      frz_m = 0; since_tick = 0; settle = 0; have_prev = 0; win_left = 0;
    end else begin
      automatic bit en = !frz_m;
      if (p_frz_wr) frz_m = p_frz_val;
      if (p_rate_wr) begin settle = SETTLE; have_prev = 0; end
      if (p_rd) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected read data", bus_rdata, 32'h0);
        end else begin
          automatic sb_item_t it = sb_q.pop_front();
          automatic logic [31:0] e = it.is_cnt ?
            32'(ticks_seen % (1 << CNT_W)) : it.exp;
          chk(bus_rdata == e, it.tag, bus_rdata, e);
        end
      end
      if (!en) begin
        chk(us_tick == 1'b0, "R9 no tick while frozen", 32'(us_tick), 32'h0);
      end else begin
        since_tick++;
        if (settle > 0) settle--;
        if (win_left > 0) begin
          if (us_tick) win_ticks++;
          win_left--;
          if (win_left == 0)
            chk(win_ticks == win_exp, {win_tag, " ticks per window"},
                32'(win_ticks), 32'(win_exp));
        end else if (win_req && settle == 0) begin
          win_left = win_len; win_ticks = 0; win_req = 0;
        end
        if (us_tick) begin
          if (gap_on && settle == 0 && have_prev)
            chk(since_tick >= gap_lo && since_tick <= gap_hi,
                {gap_tag, " tick gap"}, 32'(since_tick), 32'(gap_lo));
          have_prev = (settle == 0);
          since_tick = 0;
          ticks_seen++;
        end
      end
    end
    rst_prev  = rst_n;
    p_rd      = bus_sel && !bus_wr;
    p_frz_wr  = bus_sel && bus_wr && bus_addr == 8'h4c;
    p_frz_val = bus_wdata[0];
    p_rate_wr = bus_sel && bus_wr && bus_addr == 8'h14;
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    bus_read(8'h14, 32'h0000000b, 0, "R1 rate after reset");
    bus_read(8'h4c, 32'h0, 0, "R1 freeze after reset");
    bus_read(8'h10, 32'h0, 1, "R1 counter after reset");
    // R2 decode
    bus_read(8'h20, 32'h0, 0, "R2 unmapped reads zero");
    bus_write(8'h10, 32'hffffffff);
    bus_read(8'h10, 32'h0, 1, "R2 counter write ignored");
    bus_write(8'h24, 32'hffffffff);
    bus_read(8'h14, 32'h0000000b, 0, "R2 unmapped write ignored");
    // R3 upper bits dropped
    bus_write(8'h14, 32'habcd0102);
    bus_read(8'h14, 32'h00000102, 0, "R3 rate keeps low half");
    // R5 reference settings
    rate_case(16'h000b, 12, 12, 12, 1, "R5 12MHz");
    rate_case(16'h000c, 13, 13, 13, 1, "R5 13MHz");
    rate_case(16'h0019, 26, 26, 26, 1, "R5 26MHz");
    rate_case(16'h045f, 19, 20, 96, 5, "R5 19.2MHz");
    // R4 general ratio
    rate_case(16'h0206, 2, 3, 7, 3, "R4 3/7 ratio");
    // R6 numerator not below denominator
    rate_case(16'h0300, 1, 1, 20, 20, "R6 num>den");
    rate_case(16'h0505, 1, 1, 20, 20, "R6 num=den");
    // R9 freeze
    bus_write(8'h14, 32'h0000000b);
    gap_lo = 12; gap_hi = 12; gap_tag = "R9 phase kept"; gap_on = 1;
    repeat (SETTLE + 30) @(posedge clk);
    bus_read(8'h10, 32'h0, 1, "R7 counter equals ticks");
    bus_write(8'h4c, 32'h1);
    repeat (20) @(posedge clk);
    bus_read(8'h10, 32'h0, 1, "R9 counter held A");
    repeat (15) @(posedge clk);
    bus_read(8'h10, 32'h0, 1, "R9 counter held B");
    bus_read(8'h4c, 32'h1, 0, "R9 freeze readback");
    bus_write(8'h4c, 32'h0);
    repeat (80) @(posedge clk);
    #1 gap_on = 0;
    bus_read(8'h10, 32'h0, 1, "R7 counter after release");
    // R8 wrap
    bus_write(8'h14, 32'h00000000);
    repeat (4300) @(posedge clk);
    bus_read(8'h10, 32'h0, 1, "R8 counter after wrap");
    chk(ticks_seen >= (1 << CNT_W), "R8 wrap reached", 32'(ticks_seen), 32'(1 << CNT_W));
    repeat (4) @(posedge clk);
    summary();
  end
endmodule